// File: doc/BRIEF.md
# One-Time-Programmable Region Lock Controller

This block owns a small one-time-programmable byte space made of two serial-number regions, sixteen user regions and the lock bytes that guard them. A host issues one command per cycle as a strobe with a read/program selector, an address and a data byte. A write-enable qualifier comes from logic outside the block. One cycle later the block answers with a completion pulse, a read byte and a reject/error status. The lock bits live in the same byte space as the data. An erased bit is 1, so every region starts unlocked, and a region becomes locked once its lock bit is programmed to 0.

Programming follows the one-way rule of fuse-like storage. A bit can only go from 1 to 0, and the stored byte becomes the bitwise AND of the old byte and the new byte. A lock bit that is 0 therefore guards itself. It also blocks every later program to the bytes of its region. Out-of-range reads return 0xFF. Program requests that are out of range or aimed at a locked byte are refused and flagged as errors. Requests that lack the write-enable qualifier are refused without the error flag.

Top module: `otp_lock_ctrl`

## Requirements
- R1: After reset every byte from 0x100 to 0x215 reads 0xFF, `rd_data` is 0xFF and `done`, `rejected` and `prog_err` are 0.
- R2: A read (`cmd_prog`=0) of an address in 0x100..0x215 returns the stored byte on `rd_data` in the cycle after the strobe. `rd_data` keeps its value across program commands.
- R3: A read of an address below 0x100 or above 0x215 returns 0xFF.
- R4: An accepted program (`cmd_prog`=1) stores the old byte AND the data byte, so a bit can never return from 0 to 1.
- R5: A program with `wr_en_ok`=0 is reported with `rejected`=1 and `prog_err`=0, and it changes no byte.
- R6: A program to an address outside 0x100..0x215 is reported with `rejected`=1 and `prog_err`=1.
- R7: User region k (1..16) spans 0x114+16(k-1) to 0x114+16(k-1)+15, and region 16 also covers 0x214 and 0x215. Region k is locked when bit (k-1) mod 8 of byte 0x112 (k≤8) or byte 0x113 (k>8) is 0. A program to a locked region is rejected with `prog_err`=1 and leaves the byte unchanged.
- R8: Serial region 1 (0x102..0x109) is locked by bit 0 of byte 0x100. Serial region 2 (0x10A..0x111) is locked by bit 1 of byte 0x100. The reject behaviour is the same as in R7.
- R9: The lock bytes 0x100, 0x112 and 0x113, and the spare byte 0x101, belong to no region. They always accept programs, but a lock bit that is 0 stays 0 even when a 1 is written to it.
- R10: Bit 7 of byte 0x215 cannot be programmed and always reads 1.
- R11: A lock bit cleared by one command already guards its region for a program strobed in the very next cycle.
- R12: `done` is 1 for exactly the cycle after each strobe and 0 otherwise. `rejected` is only 1 together with `done`, and `prog_err` is only 1 together with `rejected`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_prog | input | 1 | 1 = program, 0 = read |
| cmd_addr | input | 12 | Byte address |
| cmd_wdata | input | 8 | Data byte for a program |
| wr_en_ok | input | 1 | Write-enable qualifier from the command layer |
| rd_data | output | 8 | Byte returned by the last read |
| done | output | 1 | Completion pulse, one cycle after the strobe |
| rejected | output | 1 | The completed program was refused |
| prog_err | output | 1 | The refusal was due to range or lock |

## Verification
Two functions can fall in the same cycle: updating a lock byte and checking that same lock for another command. The bench provokes this by strobing a program that clears a lock bit and, with no idle cycle between, a program into the guarded region. It then checks that the second command is refused with the error flag and that a later read shows the byte unchanged. The same back-to-back pattern is used on the next, still-unlocked region, which must be accepted. A second overlap is the one-way AND merge together with the frozen top bit of the last byte. The bench judges it by writing zeros there and reading back 0x80.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;

    typedef logic [7:0] otp_byte_t;

    typedef enum logic {
        OTP_CMD_READ = 1'b0,
        OTP_CMD_PROG = 1'b1
    } otp_cmd_e;

    // Value returned for addresses with no storage behind them
    localparam otp_byte_t OTP_BLANK = 8'hFF;

endpackage

// File: rtl/otp_region_map.sv
// Maps a byte address to its storage slot and to the lock bit guarding it.
module otp_region_map #(
    parameter int ADDR_W     = 12,
    parameter int BASE_ADDR  = 256,
    parameter int SER_BYTES  = 8,
    parameter int NUM_REG    = 16,
    parameter int REG_BYTES  = 16,
    parameter int TAIL_BYTES = 2,
    parameter int IDX_W      = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [IDX_W-1:0]  idx,
    output logic              has_lock,
    output logic [IDX_W-1:0]  lock_idx,
    output logic [2:0]        lock_bit
);
    // Layout: serial lock byte, spare byte, two serial regions,
    // user lock bytes, user regions, tail bytes folded into the last region
    localparam int SER_LOCK   = BASE_ADDR;
    localparam int SER0       = BASE_ADDR + 2;
    localparam int USR_LOCK   = SER0 + 2 * SER_BYTES;
    localparam int LOCK_BYTES = (NUM_REG + 7) / 8;
    localparam int USR0       = USR_LOCK + LOCK_BYTES;
    localparam int LAST       = USR0 + NUM_REG * REG_BYTES + TAIL_BYTES - 1;

    always_comb begin
        int a;
        int k;
        a        = int'(addr);
        k        = 0;
        in_range = (a >= BASE_ADDR) && (a <= LAST);
        idx      = in_range ? IDX_W'(a - BASE_ADDR) : '0;
        has_lock = 1'b0;
        lock_idx = '0;
        lock_bit = '0;
        if (a >= SER0 && a < USR_LOCK) begin
            has_lock = 1'b1;
            lock_idx = IDX_W'(SER_LOCK - BASE_ADDR);
            lock_bit = 3'((a - SER0) / SER_BYTES);
        end else if (a >= USR0 && a <= LAST) begin
            k = (a - USR0) / REG_BYTES;
            if (k > NUM_REG - 1) begin
                k = NUM_REG - 1;
            end
            has_lock = 1'b1;
            lock_idx = IDX_W'(USR_LOCK - BASE_ADDR + k / 8);
            lock_bit = 3'(k % 8);
        end
    end

endmodule

// File: rtl/otp_prog_rule.sv
// One-way merge of a program byte into a stored byte; frozen bits keep their value.
module otp_prog_rule #(
    parameter logic [7:0] FROZEN_MASK = 8'h80
) (
    input  logic [7:0] old_byte,
    input  logic [7:0] wdata,
    input  logic       is_frozen_byte,
    output logic [7:0] new_byte
);
    for (genvar b = 0; b < 8; b++) begin : g_bit
        if (FROZEN_MASK[b]) begin : g_frozen
            assign new_byte[b] = is_frozen_byte ? old_byte[b] : (old_byte[b] & wdata[b]);
        end else begin : g_plain
            assign new_byte[b] = old_byte[b] & wdata[b];
        end
    end

endmodule

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl #(
    parameter int ADDR_W     = 12,
    parameter int BASE_ADDR  = 256,
    parameter int SER_BYTES  = 8,
    parameter int NUM_REG    = 16,
    parameter int REG_BYTES  = 16,
    parameter int TAIL_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_prog,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wr_en_ok,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              rejected,
    output logic              prog_err
);
    import otp_lock_pkg::*;

    localparam int LAST_ADDR = BASE_ADDR + 2 + 2 * SER_BYTES + (NUM_REG + 7) / 8
                               + NUM_REG * REG_BYTES + TAIL_BYTES - 1;
    localparam int DEPTH     = LAST_ADDR - BASE_ADDR + 1;
    localparam int IDX_W     = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        otp_byte_t             rd;
        logic                  done;
        logic                  rej;
        logic                  perr;
    } st_t;

    st_t st_d, st_q;

    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic             has_lock;
    logic [IDX_W-1:0] lock_idx;
    logic [2:0]       lock_bit;
    otp_byte_t        merged;
    logic             at_last;

    otp_region_map #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .SER_BYTES (SER_BYTES),
        .NUM_REG   (NUM_REG),
        .REG_BYTES (REG_BYTES),
        .TAIL_BYTES(TAIL_BYTES),
        .IDX_W     (IDX_W)
    ) i_map (
        .addr    (cmd_addr),
        .in_range(in_range),
        .idx     (idx),
        .has_lock(has_lock),
        .lock_idx(lock_idx),
        .lock_bit(lock_bit)
    );

    assign at_last = (cmd_addr == ADDR_W'(LAST_ADDR));

    otp_prog_rule #(
        .FROZEN_MASK(8'h80)
    ) i_rule (
        .old_byte      (st_q.mem[idx]),
        .wdata         (cmd_wdata),
        .is_frozen_byte(at_last),
        .new_byte      (merged)
    );

    always_comb begin
        logic locked;
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rej  = 1'b0;
        st_d.perr = 1'b0;
        // Lock bit value 0 means the region is sealed
        locked    = has_lock && !st_q.mem[lock_idx][lock_bit];
        if (cmd_valid) begin
            st_d.done = 1'b1;
            if (otp_cmd_e'(cmd_prog) == OTP_CMD_READ) begin
                st_d.rd = in_range ? st_q.mem[idx] : OTP_BLANK;
            end else if (!wr_en_ok) begin
                st_d.rej = 1'b1;
            end else if (!in_range || locked) begin
                st_d.rej  = 1'b1;
                st_d.perr = 1'b1;
            end else begin
                st_d.mem[idx] = merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem  <= '1;
            st_q.rd   <= OTP_BLANK;
            st_q.done <= 1'b0;
            st_q.rej  <= 1'b0;
            st_q.perr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rd;
    assign done     = st_q.done;
    assign rejected = st_q.rej;
    assign prog_err = st_q.perr;

endmodule

// File: rtl/otp_lock_ctrl_chk.sv
module otp_lock_ctrl_chk #(
    parameter int ADDR_W    = 12,
    parameter int FIRST     = 256,
    parameter int LAST      = 533
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_prog,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              wr_en_ok,
    input logic [7:0]        rd_data,
    input logic              done,
    input logic              rejected,
    input logic              prog_err
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(FIRST);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(LAST);

    logic oor;
    assign oor = (cmd_addr < LO) || (cmd_addr > HI);

    AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done); // R12
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done); // R12
    AST_REJ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> done); // R12
    AST_ERR_NEEDS_REJ: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> rejected); // R12
    AST_NO_WEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_prog && !wr_en_ok |=> rejected && !prog_err); // R5
    AST_OOR_PROG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_prog && wr_en_ok && oor |=> prog_err); // R6
    AST_OOR_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_prog && oor |=> rd_data == 8'hFF); // R3
    AST_RD_HELD_ON_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_prog |=> $stable(rd_data)); // R2

endmodule

bind otp_lock_ctrl otp_lock_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .FIRST (BASE_ADDR),
    .LAST  (LAST_ADDR)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_prog (cmd_prog),
    .cmd_addr (cmd_addr),
    .wr_en_ok (wr_en_ok),
    .rd_data  (rd_data),
    .done     (done),
    .rejected (rejected),
    .prog_err (prog_err)
);

// File: tb/test_otp_lock_ctrl.sv
module test_otp_lock_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_prog;
    logic [11:0] cmd_addr;
    logic [7:0]  cmd_wdata;
    logic        wr_en_ok;
    logic [7:0]  rd_data;
    logic        done;
    logic        rejected;
    logic        prog_err;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] model [0:4095];
    logic [7:0] exp_rd;

    always #10 clk = ~clk;

    otp_lock_ctrl i_otp_lock_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_prog (cmd_prog),
        .cmd_addr (cmd_addr),
        .cmd_wdata(cmd_wdata),
        .wr_en_ok (wr_en_ok),
        .rd_data  (rd_data),
        .done     (done),
        .rejected (rejected),
        .prog_err (prog_err)
    );

    function automatic bit valid_addr(int a);
        return (a >= 256) && (a <= 533);
    endfunction

    // Returns lock byte address * 8 + bit, or -1 if the byte has no guard
    function automatic int guard_of(int a);
        int k;
        if (a >= 258 && a <= 273) return 256 * 8 + (a - 258) / 8;
        if (a >= 276 && a <= 533) begin
            k = (a - 276) / 16;
            if (k > 15) k = 15;
            return (274 + k / 8) * 8 + (k % 8);
        end
        return -1;
    endfunction

    task automatic check(bit ok, string req, logic [11:0] act, logic [11:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Issue one command at a falling edge, sample at the next falling edge
    task automatic issue(bit prog, int a, logic [7:0] d, bit wen, string req);
        bit   e_rej, e_err;
        int   g;
        logic [7:0] keep;
        e_rej = 1'b0;
        e_err = 1'b0;
        if (!prog) begin
            exp_rd = valid_addr(a) ? model[a] : 8'hFF;
        end else if (!wen) begin
            e_rej = 1'b1;
        end else begin
            g = guard_of(a);
            if (!valid_addr(a) || (g >= 0 && model[g / 8][g % 8] == 1'b0)) begin
                e_rej = 1'b1;
                e_err = 1'b1;
            end else begin
                keep = (a == 533) ? 8'h80 : 8'h00;
                model[a] = model[a] & (d | keep);
            end
        end
        cmd_valid = 1'b1;
        cmd_prog  = prog;
        cmd_addr  = 12'(a);
        cmd_wdata = d;
        wr_en_ok  = wen;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(done && rejected == e_rej && prog_err == e_err && rd_data == exp_rd, req,
              {1'b0, done, rejected, prog_err, rd_data},
              {1'b0, 1'b1, e_rej, e_err, exp_rd});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
        exp_rd    = 8'hFF;
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_prog  = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        wr_en_ok  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs after reset
        check(!done && !rejected && !prog_err && rd_data == 8'hFF, "R1 reset outputs",
              {1'b0, done, rejected, prog_err, rd_data}, 12'h0FF);
        // R1 / R3: sweep of all addresses around the space, all blank
        for (int a = 240; a <= 560; a++) issue(1'b0, a, 8'h00, 1'b0, a > 533 || a < 256 ? "R3 blank read" : "R1 erased read");
        @(negedge clk);
        check(!done, "R12 done drops when idle", {11'b0, done}, 12'h000);

        // R5: no write-enable, no change
        issue(1'b1, 336, 8'h00, 1'b0, "R5 program without enable");
        issue(1'b0, 336, 8'h00, 1'b0, "R5 byte untouched");

        // R4 / R10: program every in-range byte with a pattern, twice
        for (int a = 256; a <= 533; a++) begin
            if (a == 256 || a == 274 || a == 275) continue;
            issue(1'b1, a, 8'(a) ^ 8'h5A, 1'b1, "R4 first program");
        end
        for (int a = 276; a <= 533; a += 7) issue(1'b1, a, 8'hF0, 1'b1, "R4 second program merges by AND");
        issue(1'b1, 533, 8'h00, 1'b1, "R10 zeros to last byte");
        issue(1'b0, 533, 8'h00, 1'b0, "R10 top bit of last byte stays 1");
        for (int a = 256; a <= 533; a++) issue(1'b0, a, 8'h00, 1'b0, "R2 R4 readback");

        // R6: out of range programs
        issue(1'b1, 0,   8'h00, 1'b1, "R6 program below range");
        issue(1'b1, 255, 8'h00, 1'b1, "R6 program just below range");
        issue(1'b1, 534, 8'h00, 1'b1, "R6 program just above range");
        issue(1'b1, 4095, 8'h00, 1'b1, "R6 program at top address");

        // R7 / R11: seal each user region and test it back-to-back
        for (int k = 0; k < 16; k++) begin
            int lb;
            int first;
            lb    = 274 + k / 8;
            first = 276 + 16 * k;
            issue(1'b1, first + 1, 8'h0F, 1'b1, "R7 unlocked region accepts");
            issue(1'b1, lb, ~(8'h01 << (k % 8)), 1'b1, "R9 lock byte accepts");
            issue(1'b1, first, 8'h00, 1'b1, "R11 next-cycle program to sealed region");
            issue(1'b1, first + 15 + (k == 15 ? 2 : 0), 8'h00, 1'b1, "R7 last byte of sealed region");
            if (k < 15) issue(1'b1, first + 16, 8'h3C, 1'b1, "R7 neighbour region still open");
            issue(1'b0, first, 8'h00, 1'b0, "R7 sealed byte unchanged");
        end

        // R8: serial regions
        issue(1'b1, 261, 8'h0F, 1'b1, "R8 serial 1 open");
        issue(1'b1, 256, 8'hFE, 1'b1, "R8 seal serial 1");
        issue(1'b1, 265, 8'h00, 1'b1, "R8 serial 1 sealed");
        issue(1'b1, 266, 8'h00, 1'b1, "R8 serial 2 still open");
        issue(1'b1, 256, 8'hFD, 1'b1, "R8 seal serial 2");
        issue(1'b1, 273, 8'h00, 1'b1, "R8 serial 2 sealed");
        issue(1'b0, 265, 8'h00, 1'b0, "R8 serial 1 byte unchanged");

        // R9: lock bytes and spare byte keep accepting, zeros stay zero
        issue(1'b1, 274, 8'hFF, 1'b1, "R9 write ones to lock byte");
        issue(1'b0, 274, 8'h00, 1'b0, "R9 lock bits stay cleared");
        issue(1'b1, 257, 8'h00, 1'b1, "R9 spare byte programmable");
        issue(1'b1, 256, 8'h00, 1'b1, "R9 serial lock byte programmable");

        // Final full readback against the model
        for (int a = 250; a <= 540; a++) issue(1'b0, a, 8'h00, 1'b0, "R2 R3 final readback");
        issue(1'b1, 300, 8'h00, 1'b1, "R2 rd_data held over program");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule